// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This block holds the event status of every channel of a multi-channel DMA engine and folds it onto a small set of internal interrupt lines. Each channel can report four conditions. A descriptor completed with a request for notification. The descriptor ring ran empty. The report ring filled up. A ring error occurred. Every line has its own copy of each channel's status and its own mask. A per-line summary shows which channels are raising that line at the moment.

Software clears the completion bit of one line by writing one to it in that line's status register. The two ring-level conditions follow their ring flags and cannot be cleared by a write. The error bit stays set until software acknowledges the error through the control register of either ring of that channel. One register write port and one registered read port give access to all of this state. The OR of each line's summary drives an interrupt output.

Top module: `dma_irq_unit`

## Requirements
- R1: After synchronous reset, every status, mask and line summary reads zero, `rd_data` is zero and all `irq` outputs are low.
- R2: A status word has bit 0 = completion, bit 4 = descriptor ring empty, bit 5 = report ring full, bit 6 = ring error, and all other bits read zero. A pulse on `ev_done[c]` sets the completion bit of channel c on every line, one clock later, only when `ev_notify[c]` is high in the same cycle.
- R3: A write with `wr_sel`=0 (status) and `wr_data[0]`=1 clears the completion bit of channel `wr_ch` on line `wr_line` only. Other lines and other channels keep theirs, and a zero in bit 0 has no effect.
- R4: When a notifying completion and a clearing write hit the same completion bit in one cycle, the bit ends up set.
- R5: Status bits 4 and 5 of a channel show `lv_desc_empty` and `lv_rpt_full` as sampled at the previous clock edge, on all lines. A status write does not change them.
- R6: A pulse on `ev_ring_err[c]` sets bit 6 of channel c on all lines, and it stays set. A status write with bit 6 set leaves it set.
- R7: Bit 6 clears on a write with `wr_sel`=2 (descriptor ring control) or `wr_sel`=3 (report ring control) that has `wr_data[0]`=1 for that channel. A new error pulse in the same cycle wins and keeps the bit set.
- R8: A write with `wr_sel`=1 loads the mask of (`wr_ch`, `wr_line`). Only bits 0, 4, 5 and 6 are stored, and the other bits read zero.
- R9: The summary of line l has bit c set exactly when the status and the mask of channel c on line l share a set bit.
- R10: `irq[l]` is the OR of the summary bits of line l, registered once, so it follows a status or mask change by one clock.
- R11: The read port returns, one clock after the address, the status (`rd_sel`=0) or the mask (`rd_sel`=1) of (`rd_ch`, `rd_line`), or the summary of `rd_line` (`rd_sel`=2). `rd_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_done | input | NUM_CH | Descriptor completion pulse per channel |
| ev_notify | input | NUM_CH | Notify flag of the completing descriptor |
| ev_ring_err | input | NUM_CH | Ring error pulse per channel |
| lv_desc_empty | input | NUM_CH | Descriptor ring empty level per channel |
| lv_rpt_full | input | NUM_CH | Report ring full level per channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 status, 1 mask, 2 descriptor ring control, 3 report ring control |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_line | input | LINE_W | Interrupt line addressed by the write |
| wr_data | input | 7 | Write data in status bit layout |
| rd_sel | input | 2 | Read source: 0 status, 1 mask, 2 line summary, 3 none |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_line | input | LINE_W | Line addressed by the read |
| rd_data | output | RD_W | Registered read data |
| irq | output | NUM_LINES | Registered interrupt lines |

## Verification
On every cycle the assertions check these properties. A completion bit only rises after a notifying completion, and it only falls after a matching clear write. An error pulse always leaves the error bit set, and the error bit only falls after a ring acknowledge. A line whose masks were all zero cannot assert its interrupt, and the unused read select returns zero. Other behaviour depends on the whole register contents at once, and only the bench's sweeps show it. This covers the per-line independence of the clears, the level tracking of the ring flags, the mask bits that are dropped, and every status bit routed through every mask to the right line and channel.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int STAT_W    = 7;
  localparam int BIT_DONE  = 0;
  localparam int BIT_EMPTY = 4;
  localparam int BIT_FULL  = 5;
  localparam int BIT_ERR   = 6;
  localparam logic [STAT_W-1:0] STAT_KEEP = 7'h71;

  typedef enum logic [1:0] {
    WR_STATUS = 2'd0,
    WR_MASK   = 2'd1,
    WR_DRING  = 2'd2,
    WR_RRING  = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    RD_STATUS = 2'd0,
    RD_MASK   = 2'd1,
    RD_LINE   = 2'd2,
    RD_NONE   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/dma_irq_chan.sv
module dma_irq_chan
  import dma_irq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 evt_done,
  input  logic                                 evt_notify,
  input  logic                                 evt_err,
  input  logic                                 lvl_empty,
  input  logic                                 lvl_full,
  input  logic                                 wr_hit,
  input  logic [1:0]                           wr_sel,
  input  logic [LINE_W-1:0]                    wr_line,
  input  logic [STAT_W-1:0]                    wr_data,
  output logic [NUM_LINES-1:0][STAT_W-1:0]     stat_o,
  output logic [NUM_LINES-1:0][STAT_W-1:0]     mask_o
);
  logic [NUM_LINES-1:0]             done_q;
  logic [NUM_LINES-1:0][STAT_W-1:0] mask_q;
  logic err_q, empty_q, full_q;

  logic set_done, ring_ack, stat_wr, mask_wr;
  assign set_done = evt_done && evt_notify;
  assign stat_wr  = wr_hit && (wr_sel == WR_STATUS);
  assign mask_wr  = wr_hit && (wr_sel == WR_MASK);
  assign ring_ack = wr_hit && ((wr_sel == WR_DRING) || (wr_sel == WR_RRING)) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
      empty_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (set_done)
          done_q[l] <= 1'b1;
        else if (stat_wr && wr_line == LINE_W'(l) && wr_data[BIT_DONE])
          done_q[l] <= 1'b0;
        if (mask_wr && wr_line == LINE_W'(l))
          mask_q[l] <= wr_data & STAT_KEEP;
      end
      if (evt_err)
        err_q <= 1'b1;
      else if (ring_ack)
        err_q <= 1'b0;
      empty_q <= lvl_empty;
      full_q  <= lvl_full;
    end
  end

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      stat_o[l] = {err_q, full_q, empty_q, 3'b000, done_q[l]};
    end
  end
  assign mask_o = mask_q;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chk
      assert_done_needs_notify_R2: assert property (@(posedge clk) disable iff (rst)
        (done_q[g] && !$past(done_q[g])) |-> $past(evt_done && evt_notify));
      assert_done_clear_by_write_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(done_q[g]) && !done_q[g]) |->
          $past(wr_hit && wr_sel == WR_STATUS && wr_line == LINE_W'(g) && wr_data[0]));
    end
  endgenerate

  assert_err_sets_R6: assert property (@(posedge clk) disable iff (rst)
    $past(evt_err) |-> err_q);
  assert_err_clear_by_ring_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(err_q) |-> $past(ring_ack));
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 4
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic [NUM_CH-1:0][NUM_LINES-1:0][STAT_W-1:0]    stat_all,
  input  logic [NUM_CH-1:0][NUM_LINES-1:0][STAT_W-1:0]    mask_all,
  output logic [NUM_LINES-1:0][NUM_CH-1:0]                line_bits,
  output logic [NUM_LINES-1:0]                            irq_q
);
  logic [NUM_LINES-1:0] mask_any;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      mask_any[l] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        line_bits[l][c] = |(stat_all[c][l] & mask_all[c][l]);
        mask_any[l]     = mask_any[l] | (|mask_all[c][l]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
    end else begin
      for (int l = 0; l < NUM_LINES; l++) irq_q[l] <= |line_bits[l];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chk
      assert_masked_line_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(mask_any[g]) |-> !irq_q[g]);
    end
  endgenerate
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LINES = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int RD_W   = (NUM_CH > STAT_W) ? NUM_CH : STAT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     ev_done,
  input  logic [NUM_CH-1:0]     ev_notify,
  input  logic [NUM_CH-1:0]     ev_ring_err,
  input  logic [NUM_CH-1:0]     lv_desc_empty,
  input  logic [NUM_CH-1:0]     lv_rpt_full,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic [CH_W-1:0]       wr_ch,
  input  logic [LINE_W-1:0]     wr_line,
  input  logic [STAT_W-1:0]     wr_data,
  input  logic [1:0]            rd_sel,
  input  logic [CH_W-1:0]       rd_ch,
  input  logic [LINE_W-1:0]     rd_line,
  output logic [RD_W-1:0]       rd_data,
  output logic [NUM_LINES-1:0]  irq
);
  logic [NUM_CH-1:0][NUM_LINES-1:0][STAT_W-1:0] stat_all;
  logic [NUM_CH-1:0][NUM_LINES-1:0][STAT_W-1:0] mask_all;
  logic [NUM_LINES-1:0][NUM_CH-1:0]             line_bits;
  logic [RD_W-1:0]                              rd_q;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      dma_irq_chan #(.NUM_LINES(NUM_LINES)) i_chan (
        .clk        (clk),
        .rst        (rst),
        .evt_done   (ev_done[c]),
        .evt_notify (ev_notify[c]),
        .evt_err    (ev_ring_err[c]),
        .lvl_empty  (lv_desc_empty[c]),
        .lvl_full   (lv_rpt_full[c]),
        .wr_hit     (wr_en && (wr_ch == CH_W'(c))),
        .wr_sel     (wr_sel),
        .wr_line    (wr_line),
        .wr_data    (wr_data),
        .stat_o     (stat_all[c]),
        .mask_o     (mask_all[c])
      );
    end
  endgenerate

  dma_irq_agg #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)) i_agg (
    .clk       (clk),
    .rst       (rst),
    .stat_all  (stat_all),
    .mask_all  (mask_all),
    .line_bits (line_bits),
    .irq_q     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_sel)
        RD_STATUS: rd_q <= RD_W'(stat_all[rd_ch][rd_line]);
        RD_MASK:   rd_q <= RD_W'(mask_all[rd_ch][rd_line]);
        RD_LINE:   rd_q <= RD_W'(line_bits[rd_line]);
        default:   rd_q <= '0;
      endcase
    end
  end
  assign rd_data = rd_q;

  assert_unused_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == RD_NONE) |-> (rd_data == '0));
endmodule

// File: tb/test_dma_irq_unit.sv
module test_dma_irq_unit;
  localparam int NC = 4;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] ev_done = '0, ev_notify = '0, ev_ring_err = '0;
  logic [NC-1:0] lv_desc_empty = '0, lv_rpt_full = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [1:0] wr_ch = '0, wr_line = '0;
  logic [6:0] wr_data = '0;
  logic [1:0] rd_sel = 2'd3;
  logic [1:0] rd_ch = '0, rd_line = '0;
  logic [6:0] rd_data;
  logic [NL-1:0] irq;

  always #5 clk = ~clk;

  dma_irq_unit #(.NUM_CH(NC), .NUM_LINES(NL)) i_dma_irq_unit (
    .clk(clk), .rst(rst), .ev_done(ev_done), .ev_notify(ev_notify),
    .ev_ring_err(ev_ring_err), .lv_desc_empty(lv_desc_empty), .lv_rpt_full(lv_rpt_full),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch), .wr_line(wr_line), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_ch(rd_ch), .rd_line(rd_line), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  logic       m_done [NC][NL];
  logic [6:0] m_mask [NC][NL];
  logic       m_err [NC];
  logic       m_empty [NC];
  logic       m_full [NC];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_stat(input int c, input int l);
    return {m_err[c], m_full[c], m_empty[c], 3'b000, m_done[c][l]};
  endfunction

  function automatic logic [NC-1:0] exp_line(input int l);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = |(exp_stat(c, l) & m_mask[c][l]);
    return v;
  endfunction

  // One clock with the given stimulus; the model follows the requirements.
  task automatic cyc(input logic [NC-1:0] dn, input logic [NC-1:0] nt, input logic [NC-1:0] er,
                     input logic we, input logic [1:0] sel, input int ch, input int ln,
                     input logic [6:0] d);
    ev_done = dn; ev_notify = nt; ev_ring_err = er;
    wr_en = we; wr_sel = sel; wr_ch = 2'(ch); wr_line = 2'(ln); wr_data = d;
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      for (int l = 0; l < NL; l++) begin
        if (dn[c] && nt[c]) m_done[c][l] = 1'b1;
        else if (we && sel == 2'd0 && ch == c && ln == l && d[0]) m_done[c][l] = 1'b0;
        if (we && sel == 2'd1 && ch == c && ln == l) m_mask[c][l] = d & 7'h71;
      end
      if (er[c]) m_err[c] = 1'b1;
      else if (we && (sel == 2'd2 || sel == 2'd3) && ch == c && d[0]) m_err[c] = 1'b0;
      m_empty[c] = lv_desc_empty[c];
      m_full[c]  = lv_rpt_full[c];
    end
    @(negedge clk);
    ev_done = '0; ev_notify = '0; ev_ring_err = '0; wr_en = 1'b0;
  endtask

  task automatic idle();
    cyc('0, '0, '0, 1'b0, 2'd0, 0, 0, 7'h0);
  endtask

  task automatic rd(input logic [1:0] sel, input int ch, input int ln, output int v);
    rd_sel = sel; rd_ch = 2'(ch); rd_line = 2'(ln);
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  // Compare every register and the interrupt lines against the model.
  task automatic verify(input string req);
    int v;
    for (int c = 0; c < NC; c++) begin
      for (int l = 0; l < NL; l++) begin
        rd(2'd0, c, l, v);
        check(req, $sformatf("status ch%0d line%0d", c, l), v, int'(exp_stat(c, l)));
        rd(2'd1, c, l, v);
        check(req, $sformatf("mask ch%0d line%0d", c, l), v, int'(m_mask[c][l]));
      end
    end
    for (int l = 0; l < NL; l++) begin
      rd(2'd2, 0, l, v);
      check("R9", $sformatf("summary line%0d (%s)", l, req), v, int'(exp_line(l)));
      check("R10", $sformatf("irq line%0d (%s)", l, req), int'(irq[l]), int'(|exp_line(l)));
    end
    rd(2'd3, 1, 1, v);
    check("R11", "unused select", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    for (int c = 0; c < NC; c++) begin
      m_err[c] = 0; m_empty[c] = 0; m_full[c] = 0;
      for (int l = 0; l < NL; l++) begin m_done[c][l] = 0; m_mask[c][l] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "rd_data after reset", int'(rd_data), 0);
    check("R1", "irq after reset", int'(irq), 0);
    verify("R1");

    // R2: completion without notify does nothing; with notify sets all lines
    cyc(4'b0010, 4'b0000, '0, 1'b0, 2'd0, 0, 0, 7'h0);
    cyc(4'b0001, 4'b0100, '0, 1'b0, 2'd0, 0, 0, 7'h0);
    verify("R2 no notify");
    cyc(4'b0101, 4'b0101, '0, 1'b0, 2'd0, 0, 0, 7'h0);
    verify("R2 notify");

    // R3: per-line clear, zero data has no effect
    cyc('0, '0, '0, 1'b1, 2'd0, 0, 2, 7'h7E);
    cyc('0, '0, '0, 1'b1, 2'd0, 0, 1, 7'h01);
    verify("R3");

    // R4: set and clear on the same bit
    cyc(4'b0001, 4'b0001, '0, 1'b1, 2'd0, 0, 1, 7'h01);
    rd(2'd0, 0, 1, v);
    check("R4", "set wins over clear", v & 1, 1);

    // R5: ring levels, not writable
    lv_desc_empty = 4'b1001; lv_rpt_full = 4'b0110;
    idle();
    cyc('0, '0, '0, 1'b1, 2'd0, 0, 0, 7'h30);
    cyc('0, '0, '0, 1'b1, 2'd0, 1, 3, 7'h30);
    verify("R5 levels high");
    lv_desc_empty = 4'b0000; lv_rpt_full = 4'b0100;
    idle();
    verify("R5 levels changed");

    // R6/R7: ring error
    cyc('0, '0, 4'b1010, 1'b0, 2'd0, 0, 0, 7'h0);
    cyc('0, '0, '0, 1'b1, 2'd0, 1, 0, 7'h40);
    cyc('0, '0, '0, 1'b1, 2'd2, 3, 0, 7'h7E);
    verify("R6");
    cyc('0, '0, '0, 1'b1, 2'd2, 1, 0, 7'h01);
    cyc('0, '0, '0, 1'b1, 2'd3, 3, 2, 7'h01);
    verify("R7 ack");
    cyc('0, '0, 4'b0100, 1'b1, 2'd3, 2, 0, 7'h01);
    rd(2'd0, 2, 3, v);
    check("R7", "error pulse wins over ack", (v >> 6) & 1, 1);

    // R8: mask stores only defined bits
    cyc('0, '0, '0, 1'b1, 2'd1, 3, 2, 7'h7F);
    rd(2'd1, 3, 2, v);
    check("R8", "mask kept bits", v, 7'h71);
    cyc('0, '0, '0, 1'b1, 2'd1, 3, 2, 7'h00);

    // clean slate for the sweep
    lv_desc_empty = '0; lv_rpt_full = '0;
    for (int c = 0; c < NC; c++) begin
      cyc('0, '0, '0, 1'b1, 2'd2, c, 0, 7'h01);
      for (int l = 0; l < NL; l++) cyc('0, '0, '0, 1'b1, 2'd0, c, l, 7'h7F);
    end
    verify("R1 cleared");

    // R9/R10: every channel, line and status bit routed through its mask
    for (int c = 0; c < NC; c++) begin
      for (int l = 0; l < NL; l++) begin
        for (int k = 0; k < 4; k++) begin
          int b;
          b = (k == 0) ? 0 : k + 3;
          cyc('0, '0, '0, 1'b1, 2'd1, c, l, 7'(1 << b));
          case (k)
            0: cyc(4'(1 << c), 4'(1 << c), '0, 1'b0, 2'd0, 0, 0, 7'h0);
            1: begin lv_desc_empty[c] = 1'b1; idle(); end
            2: begin lv_rpt_full[c] = 1'b1; idle(); end
            default: cyc('0, '0, 4'(1 << c), 1'b0, 2'd0, 0, 0, 7'h0);
          endcase
          idle();
          check("R10", $sformatf("irq ch%0d line%0d bit%0d", c, l, b), int'(irq), 1 << l);
          rd(2'd2, 0, l, v);
          check("R9", $sformatf("summary ch%0d line%0d bit%0d", c, l, b), v, 1 << c);
          cyc('0, '0, '0, 1'b1, 2'd1, c, l, 7'h00);
          lv_desc_empty = '0; lv_rpt_full = '0;
          cyc('0, '0, '0, 1'b1, 2'd3, c, 0, 7'h01);
          for (int q = 0; q < NL; q++) cyc('0, '0, '0, 1'b1, 2'd0, c, q, 7'h01);
          idle();
          check("R10", $sformatf("irq drop ch%0d line%0d", c, l), int'(irq), 0);
        end
      end
    end

    // mixed final pattern against the model
    cyc('0, '0, '0, 1'b1, 2'd1, 2, 3, 7'h71);
    cyc('0, '0, '0, 1'b1, 2'd1, 1, 0, 7'h10);
    cyc(4'b0100, 4'b0100, 4'b0010, 1'b0, 2'd0, 0, 0, 7'h0);
    lv_desc_empty = 4'b0010;
    idle();
    verify("R9 mixed");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule